// File: doc/BRIEF.md
# Indexed Peripheral Clock Gate Controller

This block keeps the clock settings of a bank of peripherals behind one shared control word. Each write names a peripheral by its identifier. A flag in the same word says what the write does. With the flag set, the write stores a new enable bit and a 2-bit division code for that peripheral. With the flag clear, the write changes nothing and only points the readback port at that peripheral. The readback port always shows the identifier currently pointed at, together with that peripheral's stored enable bit and division code.

For every peripheral the block drives a clock-enable strobe on the parent clock. An enabled peripheral with division code d gets a one-cycle strobe once every 2^d parent cycles, so d = 0 to 3 gives the parent rate divided by 1, 2, 4 or 8. A disabled peripheral gets no strobe. A small number of low identifiers are hard-wired. They cannot be written, always run undivided and always report as enabled.

A change of enable or division code restarts that peripheral's phase, and the first strobe comes in the cycle that follows the write. A write that repeats the stored settings leaves the phase alone. Generating the parent clock and attaching the block to a bus are done outside the block.

Top module: `pclk_index_ctrl`

## Requirements
- R1: After reset every writable peripheral is disabled with division code 0. The pointer selects identifier 0, so the readback shows identifier 0 as enabled with code 0. Only the strobes of the hard-wired identifiers are high.
- R2: A write with the command flag (bit 12) set stores enable (bit 28) and division code (bits 17:16) for the identifier in bits 5:0. The readback shows the new values in the cycle after the write.
- R3: A write with the command flag clear leaves all stored settings and all strobes unchanged.
- R4: The readback word puts the pointed-at identifier in bits 5:0, its division code in bits 17:16 and its enable in bit 28. Every other bit reads as zero, whatever was written there.
- R5: Identifiers 0 and 1 ignore command writes. They always read back as enabled with code 0, and their strobes are high in every cycle.
- R6: An enabled writable peripheral with code d strobes for exactly one cycle in every 2^d. The first strobe comes in the cycle right after the write that changed its settings.
- R7: A command write with enable 0 and code 0 turns the peripheral off. A disabled peripheral never strobes.
- R8: A command write that repeats the stored enable and code does not move the phase of that peripheral's strobe. A write that changes either value restarts the phase.
- R9: Every write, with or without the command flag, moves the readback pointer to its identifier from the following cycle on.
- R10: A command write to one identifier leaves the settings and strobe phases of all other identifiers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: identifier 5:0, command 12, code 17:16, enable 28 |
| rd_data | output | 32 | Readback of the pointed-at peripheral |
| clk_en | output | 64 | Per-peripheral clock-enable strobes, bit n for identifier n |

## Verification
A corrupted settings entry shows up two ways. When it is pointed at, the readback is wrong in the cycle after the write. Its strobe pattern is also wrong within at most eight parent cycles, because eight cycles cover the longest division period. A phase counter that fails to restart, or restarts when it should not, puts the strobes at the wrong offset from the write edge, so every strobe is compared cycle by cycle with an arithmetic model of elapsed cycles modulo 2^d. A broken pointer appears at once as a wrong identifier field.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

   typedef enum logic [1:0] {
      WR_IDLE   = 2'd0,
      WR_SELECT = 2'd1,
      WR_SET    = 2'd2
   } wr_kind_e;

   // Mask of the low 'd' bits, used to find the strobe slot of a phase counter.
   function automatic logic [7:0] low_mask(input logic [2:0] d);
      return 8'((9'd1 << d) - 9'd1);
   endfunction

endpackage

// File: rtl/pclk_wr_decode.sv
module pclk_wr_decode
   import pclk_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ID_W      = 6,
   parameter int unsigned DIV_W     = 2,
   parameter int unsigned NUM_FIXED = 2,
   parameter int unsigned ID_LSB    = 0,
   parameter int unsigned CMD_BIT   = 12,
   parameter int unsigned DIV_LSB   = 16,
   parameter int unsigned EN_BIT    = 28
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output wr_kind_e          kind,
   output logic [ID_W-1:0]   dec_id,
   output logic [DIV_W-1:0]  dec_div,
   output logic              dec_en
);

   logic fixed_id;

   assign dec_id   = wr_data[ID_LSB +: ID_W];
   assign dec_div  = wr_data[DIV_LSB +: DIV_W];
   assign dec_en   = wr_data[EN_BIT];
   assign fixed_id = (int'(dec_id) < int'(NUM_FIXED));

   always_comb begin
      kind = WR_IDLE;
      if (wr_en) begin
         if (wr_data[CMD_BIT] && !fixed_id) kind = WR_SET;
         else                               kind = WR_SELECT;
      end
   end

endmodule

// File: rtl/pclk_entry_store.sv
module pclk_entry_store
   import pclk_pkg::*;
#(
   parameter int unsigned NUM_IDS   = 64,
   parameter int unsigned NUM_FIXED = 2,
   parameter int unsigned ID_W      = 6,
   parameter int unsigned DIV_W     = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  wr_kind_e                 kind,
   input  logic [ID_W-1:0]          set_id,
   input  logic                     set_en,
   input  logic [DIV_W-1:0]         set_div,
   output logic [NUM_IDS-1:0]       en_vec,
   output logic [NUM_IDS*DIV_W-1:0] div_flat,
   output logic [NUM_IDS-1:0]       restart_vec
);

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_entry
      if (i < NUM_FIXED) begin : g_fixed
         assign en_vec[i]                  = 1'b1;
         assign div_flat[i*DIV_W +: DIV_W] = '0;
         assign restart_vec[i]             = 1'b0;
      end else begin : g_rw
         logic             en_q;
         logic [DIV_W-1:0] div_q;
         logic             hit;

         assign hit = (kind == WR_SET) && (int'(set_id) == i);
         // Restart only when the stored settings really change.
         assign restart_vec[i] = hit && ((set_en != en_q) || (set_div != div_q));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q  <= 1'b0;
               div_q <= '0;
            end else if (hit) begin
               en_q  <= set_en;
               div_q <= set_div;
            end
         end

         assign en_vec[i]                  = en_q;
         assign div_flat[i*DIV_W +: DIV_W] = div_q;
      end
   end

endmodule

// File: rtl/pclk_strobe_gen.sv
module pclk_strobe_gen
   import pclk_pkg::*;
#(
   parameter int unsigned DIV_W = 2,
   localparam int unsigned CNT_W = (1 << DIV_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             stb
);

   logic [CNT_W-1:0] phase_q;
   logic [CNT_W-1:0] slot_mask;

   always_ff @(posedge clk) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else              phase_q <= phase_q + 1'b1;
   end

   assign slot_mask = CNT_W'(low_mask(3'(div)));
   assign stb       = en && ((phase_q & slot_mask) == '0);

endmodule

// File: rtl/pclk_index_ctrl.sv
module pclk_index_ctrl
   import pclk_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ID_W      = 6,
   parameter int unsigned NUM_IDS   = 64,
   parameter int unsigned NUM_FIXED = 2,
   parameter int unsigned DIV_W     = 2,
   parameter int unsigned ID_LSB    = 0,
   parameter int unsigned CMD_BIT   = 12,
   parameter int unsigned DIV_LSB   = 16,
   parameter int unsigned EN_BIT    = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic [NUM_IDS-1:0] clk_en
);

   if (NUM_IDS != (1 << ID_W)) begin : g_bad_ids
      $error("NUM_IDS must equal 2**ID_W");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("DIV_W must be 1..3");
   end
   if (NUM_FIXED >= NUM_IDS) begin : g_bad_fixed
      $error("NUM_FIXED must be below NUM_IDS");
   end
   if (ID_LSB + ID_W > DATA_W || DIV_LSB + DIV_W > DATA_W ||
       EN_BIT >= DATA_W || CMD_BIT >= DATA_W) begin : g_bad_fields
      $error("control fields exceed DATA_W");
   end

   wr_kind_e                 kind;
   logic [ID_W-1:0]          dec_id;
   logic [DIV_W-1:0]         dec_div;
   logic                     dec_en;
   logic [NUM_IDS-1:0]       en_vec;
   logic [NUM_IDS*DIV_W-1:0] div_flat;
   logic [NUM_IDS-1:0]       restart_vec;
   logic [ID_W-1:0]          sel_q;

   pclk_wr_decode #(
      .DATA_W(DATA_W), .ID_W(ID_W), .DIV_W(DIV_W), .NUM_FIXED(NUM_FIXED),
      .ID_LSB(ID_LSB), .CMD_BIT(CMD_BIT), .DIV_LSB(DIV_LSB), .EN_BIT(EN_BIT)
   ) u_dec (
      .wr_en(wr_en), .wr_data(wr_data), .kind(kind),
      .dec_id(dec_id), .dec_div(dec_div), .dec_en(dec_en)
   );

   pclk_entry_store #(
      .NUM_IDS(NUM_IDS), .NUM_FIXED(NUM_FIXED), .ID_W(ID_W), .DIV_W(DIV_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .kind(kind), .set_id(dec_id),
      .set_en(dec_en), .set_div(dec_div),
      .en_vec(en_vec), .div_flat(div_flat), .restart_vec(restart_vec)
   );

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_stb
      if (i < NUM_FIXED) begin : g_fixed
         assign clk_en[i] = 1'b1;
      end else begin : g_div
         pclk_strobe_gen #(.DIV_W(DIV_W)) u_gen (
            .clk(clk), .rst_n(rst_n), .restart(restart_vec[i]),
            .en(en_vec[i]), .div(div_flat[i*DIV_W +: DIV_W]), .stb(clk_en[i])
         );
      end
   end

   // Readback pointer: every write retargets it.
   always_ff @(posedge clk) begin
      if (!rst_n)               sel_q <= '0;
      else if (kind != WR_IDLE) sel_q <= dec_id;
   end

   always_comb begin
      rd_data                       = '0;
      rd_data[ID_LSB +: ID_W]       = sel_q;
      rd_data[DIV_LSB +: DIV_W]     = div_flat[sel_q*DIV_W +: DIV_W];
      rd_data[EN_BIT]               = en_vec[sel_q];
   end

endmodule

// File: rtl/pclk_index_ctrl_checker.sv
module pclk_index_ctrl_checker #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ID_W      = 6,
   parameter int unsigned NUM_IDS   = 64,
   parameter int unsigned NUM_FIXED = 2,
   parameter int unsigned DIV_W     = 2,
   parameter int unsigned ID_LSB    = 0,
   parameter int unsigned CMD_BIT   = 12,
   parameter int unsigned DIV_LSB   = 16,
   parameter int unsigned EN_BIT    = 28
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  rd_data,
   input logic [NUM_IDS-1:0] clk_en
);

   localparam logic [DATA_W-1:0] USED =
      (DATA_W'((1 << ID_W) - 1) << ID_LSB) |
      (DATA_W'((1 << DIV_W) - 1) << DIV_LSB) |
      (DATA_W'(1) << EN_BIT);

   logic [ID_W-1:0]  rb_id;
   logic [DIV_W-1:0] rb_div;
   logic             rb_en;
   logic [ID_W-1:0]  w_id;

   assign rb_id  = rd_data[ID_LSB +: ID_W];
   assign rb_div = rd_data[DIV_LSB +: DIV_W];
   assign rb_en  = rd_data[EN_BIT];
   assign w_id   = wr_data[ID_LSB +: ID_W];

   a_r2_set_reported: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[CMD_BIT] && int'(w_id) >= int'(NUM_FIXED)) |=>
      (rb_en == $past(wr_data[EN_BIT]) && rb_div == $past(wr_data[DIV_LSB +: DIV_W])));

   a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~USED) == '0);

   a_r5_fixed_running: assert property (@(posedge clk) disable iff (!rst_n)
      &clk_en[NUM_FIXED-1:0]);

   a_r5_fixed_report: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rb_id) < int'(NUM_FIXED)) |-> (rb_en && rb_div == '0));

   a_r6_undivided: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_en && rb_div == '0) |-> clk_en[rb_id]);

   a_r6_gap_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_en && rb_div != '0 && clk_en[rb_id] && !wr_en) |=>
      !clk_en[$past(rb_id)]);

   a_r7_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rb_en |-> !clk_en[rb_id]);

   a_r9_pointer_follows: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rb_id == $past(w_id)));

endmodule

bind pclk_index_ctrl pclk_index_ctrl_checker #(
   .DATA_W(DATA_W), .ID_W(ID_W), .NUM_IDS(NUM_IDS), .NUM_FIXED(NUM_FIXED),
   .DIV_W(DIV_W), .ID_LSB(ID_LSB), .CMD_BIT(CMD_BIT), .DIV_LSB(DIV_LSB),
   .EN_BIT(EN_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .clk_en(clk_en)
);

// File: tb/pclk_index_ctrl_bench.sv
module pclk_index_ctrl_bench;

   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [N-1:0] clk_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   bit       m_en  [N];
   int       m_div [N];
   int       m_chg [N];
   int       m_sel;

   always #5 clk = ~clk;

   pclk_index_ctrl u_pclk_index_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .clk_en(clk_en)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      cyc = cyc + 1;
      @(negedge clk);
   endtask

   function automatic logic [31:0] word(input int id, input bit cmd, input bit en,
                                        input int div, input logic [31:0] junk);
      logic [31:0] w;
      w = junk & ~32'h1003_103F;
      w[5:0]   = 6'(id);
      w[12]    = cmd;
      w[17:16] = 2'(div);
      w[28]    = en;
      return w;
   endfunction

   function automatic logic [N-1:0] exp_stb();
      logic [N-1:0] e;
      for (int i = 0; i < N; i++) begin
         if (i < 2) e[i] = 1'b1;
         else e[i] = m_en[i] && (((cyc - m_chg[i]) % (1 << m_div[i])) == 0);
      end
      return e;
   endfunction

   function automatic logic [31:0] exp_rd();
      logic [31:0] e;
      e = '0;
      e[5:0] = 6'(m_sel);
      if (m_sel < 2) e[28] = 1'b1;
      else begin
         e[28]    = m_en[m_sel];
         e[17:16] = 2'(m_div[m_sel]);
      end
      return e;
   endfunction

   task automatic wr(input int id, input bit cmd, input bit en, input int div,
                     input logic [31:0] junk = '0);
      wr_en   = 1'b1;
      wr_data = word(id, cmd, en, div, junk);
      tick();
      wr_en   = 1'b0;
      wr_data = '0;
      m_sel   = id;
      if (cmd && id >= 2) begin
         if (m_en[id] != en || m_div[id] != div) m_chg[id] = cyc;
         m_en[id]  = en;
         m_div[id] = div;
      end
   endtask

   task automatic run(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         check(clk_en === exp_stb(), req, clk_en, exp_stb());
         tick();
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_en[i] = 0; m_div[i] = 0; m_chg[i] = 0;
      end
      m_sel = 0;
      tick(); tick();
      rst_n = 1'b1;
      cyc = 0;

      // R1: reset state
      check(rd_data === 32'h1000_0000, "R1 readback", rd_data, 32'h1000_0000);
      check(clk_en === 64'h3, "R1 strobes", clk_en, 64'h3);
      run(4, "R1");

      // R3/R9: select-only write carrying settings bits stores nothing
      wr(5, 0, 1, 3);
      check(rd_data === exp_rd(), "R3 R9 select only", rd_data, exp_rd());
      run(8, "R3");

      // R2/R9/R10: program every writable id, divider cycles through 0..3
      for (int id = 2; id < N; id++) begin
         wr(id, 1, 1, id % 4);
         check(rd_data === exp_rd(), "R2 R9 stored", rd_data, exp_rd());
         check(clk_en === exp_stb(), "R6 R10 strobes", clk_en, exp_stb());
      end
      run(20, "R6 R10");

      // R4: readback sweep with junk in unused write bits
      for (int id = 0; id < N; id++) begin
         wr(id, 0, 0, 0, 32'hEFFC_EFC0);
         check(rd_data === exp_rd(), "R4 readback", rd_data, exp_rd());
      end

      // R5: fixed identifiers ignore command writes
      wr(0, 1, 0, 3);
      check(rd_data === 32'h1000_0000, "R5 id0", rd_data, 32'h1000_0000);
      wr(1, 1, 0, 2);
      check(rd_data === 32'h1000_0001, "R5 id1", rd_data, 32'h1000_0001);
      run(8, "R5");

      // R8: identical rewrite keeps phase, a change restarts it
      tick(); tick(); tick();
      wr(7, 1, 1, 3);
      run(10, "R8 same settings");
      wr(7, 1, 1, 2);
      run(10, "R8 restart");
      wr(11, 1, 1, 3, 32'h2000_0000);
      run(9, "R8 R6 div8");

      // R7: disable
      wr(9, 1, 0, 0);
      check(rd_data === exp_rd(), "R7 readback", rd_data, exp_rd());
      check(clk_en[9] === 1'b0, "R7 quiet", 64'(clk_en[9]), 64'd0);
      run(10, "R7");

      // R6: each divider on one id, watched across a full period twice
      for (int d = 0; d < 4; d++) begin
         wr(20, 1, 1, d);
         run(16, "R6 sweep");
      end

      // R10: disable all writable ids, then re-enable one
      for (int id = 2; id < N; id++) wr(id, 1, 0, 0);
      run(8, "R7 R10 all off");
      check(clk_en === 64'h3, "R7 all off", clk_en, 64'h3);
      wr(40, 1, 1, 1);
      run(8, "R10 single");

      done = 1;
      report();
   end

endmodule